// File: doc/BRIEF.md
# Multi-Domain Time-of-Day Counter

This block keeps up to three independent time-of-day clocks for precision timing. Each domain holds a 48-bit seconds count, a 30-bit nanoseconds count and a hidden fractional remainder. On every core clock edge, each enabled domain adds a 64-bit unsigned nanosecond increment with 59 fractional bits. When the nanoseconds reach one second, they roll over into the seconds count. Each domain has its own increment register. Software writes it as two 32-bit words into a staging register. While the domain's rate-hold bit is set, the staged value is kept away from the counter.

Software reaches the domains through a single access port. It writes a seconds high word, a seconds low word and a nanoseconds word into shadow registers. It then issues an action code with a domain number. The port is a small state machine whose state is the last action code accepted. The states are PS_IDLE (code 0), PS_LOAD (1), PS_SAVE (2), PS_CLOCK (3), PS_DELTA (4) and PS_TOD (5). Any valid command carrying codes 0 to 5 moves the machine to the matching state. Codes 6 and 7 leave it where it is.

A load or a delta acts on the time only when it is issued from PS_IDLE. A save acts from any state. A nanosecond value from 0x3FFFFFF0 to 0x3FFFFFFF stands for a time just below a whole second: the true value is one second less than the stored seconds plus (low four bits + 999999984) ns.

Top module: `tod_keeper`

## Requirements
- R1: After reset, every domain reads 0 s and 0 ns, the shadow registers read zero, and every domain's active increment is the NOMINAL_INC parameter (default 0x1FF0000000000000, 3.9921875 ns).
- R2: On each clock edge where a domain's bit in dom_ena is 1 and no load or delta hits it, the domain adds the integer part of its increment (bits 63:59) to the nanoseconds. It also adds the carry out of adding bits 58:0 to its kept fractional remainder, so 128 cycles at 0x1FF0000000000000 give exactly 511 ns.
- R3: A domain whose dom_ena bit is 0 does not change unless a load or a delta hits it.
- R4: When a counting step brings the nanoseconds to 1,000,000,000 or more, 1,000,000,000 is subtracted and the seconds go up by one on the same edge.
- R5: rate_wr_lo writes wdata into bits 31:0 and rate_wr_hi writes wdata into bits 63:32 of the staging register of domain rate_dom. The active increment copies the staging register on each edge where that domain's rate_hold bit is 0. While the bit is 1, the old increment stays in use.
- R6: Action 1 (load), issued while the port is in PS_IDLE, copies the shadow seconds and nanoseconds into domain cmd_dom and clears that domain's fractional remainder. Issued from any other state, it changes nothing.
- R7: Action 2 (save) copies the selected domain's seconds and nanoseconds, as they were before that edge, into the shadow registers, which rd_sec and rd_ns show from the next cycle on.
- R8: Action 4 (delta), issued from PS_IDLE, adds the shadow nanoseconds, read as a 30-bit two's-complement number, to the selected domain. A result below zero borrows one second and adds 1,000,000,000. A result of one second or more carries one second. From any other state, delta changes nothing.
- R9: A domain whose nanoseconds lie in 0x3FFFFFF0..0x3FFFFFFF counts modulo 2^30 without touching the seconds. A delta treats such a value as (value - 2^30) ns.
- R10: Actions 3 and 5 change no time but leave PS_IDLE. Codes 6 and 7 change neither the time nor the port state.
- R11: sh_wr_sec_hi writes wdata[15:0] into seconds bits 47:32. sh_wr_sec_lo writes wdata into seconds bits 31:0. sh_wr_ns writes wdata[29:0] into the nanoseconds. A save on the same edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_ena | input | NUM_DOM | Per-domain count enable |
| rate_hold | input | NUM_DOM | Per-domain gate that keeps the active increment |
| wdata | input | 32 | Write data for rate and shadow writes |
| rate_wr_lo | input | 1 | Write the low word of the staged increment |
| rate_wr_hi | input | 1 | Write the high word of the staged increment |
| rate_dom | input | DOM_W | Domain whose staged increment is written |
| sh_wr_sec_hi | input | 1 | Write shadow seconds bits 47:32 |
| sh_wr_sec_lo | input | 1 | Write shadow seconds bits 31:0 |
| sh_wr_ns | input | 1 | Write shadow nanoseconds |
| cmd_valid | input | 1 | Command strobe |
| cmd_action | input | 3 | Action code |
| cmd_dom | input | DOM_W | Domain the command acts on |
| rd_sec | output | SEC_W | Shadow seconds |
| rd_ns | output | NS_W | Shadow nanoseconds |

## Verification
A shadow write or a save sampled at edge t shows on rd_sec and rd_ns right after t. A load or a delta lands in the domain at edge t. A count enable seen at edge t adds one increment at that edge. A rate change appears one edge after rate_hold is seen low. The bench therefore drives every stimulus at a falling edge and holds it across exactly one rising edge. It reads a domain only through a save, so a save issued after N enabled edges captures exactly N increments, and it compares rd_sec and rd_ns at the following falling edge.

// File: rtl/tod_pkg.sv
package tod_pkg;

    // Action codes of the access port; the numeric values are decoded by software.
    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_LOAD  = 3'd1,
        ACT_SAVE  = 3'd2,
        ACT_CLOCK = 3'd3,
        ACT_DELTA = 3'd4,
        ACT_TOD   = 3'd5
    } tod_act_e;

    // Port state: the last accepted action.
    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,
        PS_LOAD  = 3'd1,
        PS_SAVE  = 3'd2,
        PS_CLOCK = 3'd3,
        PS_DELTA = 3'd4,
        PS_TOD   = 3'd5
    } port_st_e;

    localparam int unsigned NS_PER_SEC = 1_000_000_000;
    localparam int unsigned NEG_BAND   = 16;

    // Nominal increments, 59 fractional bits.
    localparam logic [63:0] INC_250MHZ = 64'h1FF0_0000_0000_0000;
    localparam logic [63:0] INC_500MHZ = 64'h0FF8_0000_0000_0000;
    localparam logic [63:0] INC_625MHZ = 64'h0CC6_6666_6666_6666;

endpackage

// File: rtl/tod_port_fsm.sv
module tod_port_fsm
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_action,
    output port_st_e   state,
    output logic       do_load,
    output logic       do_save,
    output logic       do_delta
);

    port_st_e st_q;
    port_st_e st_d;

    always_comb begin : next_state
        st_d = st_q;
        if (cmd_valid) begin
            unique case (cmd_action)
                ACT_IDLE:  st_d = PS_IDLE;
                ACT_LOAD:  st_d = PS_LOAD;
                ACT_SAVE:  st_d = PS_SAVE;
                ACT_CLOCK: st_d = PS_CLOCK;
                ACT_DELTA: st_d = PS_DELTA;
                ACT_TOD:   st_d = PS_TOD;
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) begin
            st_q <= PS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin : strobes
        do_load  = 1'b0;
        do_save  = 1'b0;
        do_delta = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_action)
                ACT_LOAD:  do_load  = (st_q == PS_IDLE);
                ACT_DELTA: do_delta = (st_q == PS_IDLE);
                ACT_SAVE:  do_save  = 1'b1;
                default: ;
            endcase
        end
    end

    assign state = st_q;

endmodule

// File: rtl/tod_rate_reg.sv
module tod_rate_reg #(
    parameter int                 INC_W = 64,
    parameter logic [INC_W-1:0]   INIT  = '0,
    localparam int                HI_W  = INC_W - 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    output logic [INC_W-1:0] active
);

    logic [INC_W-1:0] staged_q;
    logic [INC_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= INIT;
            active_q <= INIT;
        end else begin
            if (wr_lo) begin
                staged_q[31:0] <= wdata;
            end
            if (wr_hi) begin
                staged_q[INC_W-1:32] <= wdata[HI_W-1:0];
            end
            if (!hold) begin
                active_q <= staged_q;
            end
        end
    end

    assign active = active_q;

endmodule

// File: rtl/tod_domain.sv
module tod_domain
    import tod_pkg::*;
#(
    parameter int  SEC_W  = 48,
    parameter int  NS_W   = 30,
    parameter int  INC_W  = 64,
    parameter int  FRAC_W = 59,
    localparam int SUM_W  = NS_W + 2,
    localparam int SW     = NS_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena,
    input  logic [INC_W-1:0] inc,
    input  logic             ld,
    input  logic [SEC_W-1:0] ld_sec,
    input  logic [NS_W-1:0]  ld_ns,
    input  logic             dl,
    input  logic [NS_W-1:0]  dl_ns,
    output logic [SEC_W-1:0] sec,
    output logic [NS_W-1:0]  ns
);

    localparam logic [NS_W-1:0]         BAND_LO   = {NS_W{1'b1}} - NS_W'(NEG_BAND - 1);
    localparam logic [SUM_W-1:0]        BILLION_U = SUM_W'(NS_PER_SEC);
    localparam logic signed [SW-1:0]    BILLION_S = SW'(NS_PER_SEC);

    logic [SEC_W-1:0]       sec_q;
    logic [NS_W-1:0]        ns_q;
    logic [FRAC_W-1:0]      frac_q;

    logic                   in_band;
    logic [FRAC_W:0]        frac_sum;
    logic [SUM_W-1:0]       ns_add;
    logic signed [SW-1:0]   cur_s;
    logic signed [SW-1:0]   step_s;
    logic signed [SW-1:0]   dsum;

    always_comb begin
        in_band  = (ns_q >= BAND_LO);
        frac_sum = {1'b0, frac_q} + {1'b0, inc[FRAC_W-1:0]};
        ns_add   = {2'b00, ns_q} + SUM_W'(inc[INC_W-1:FRAC_W]) + SUM_W'(frac_sum[FRAC_W]);
        cur_s    = in_band ? {3'b111, ns_q} : {3'b000, ns_q};
        step_s   = {{3{dl_ns[NS_W-1]}}, dl_ns};
        dsum     = cur_s + step_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            ns_q   <= '0;
            frac_q <= '0;
        end else if (ld) begin
            sec_q  <= ld_sec;
            ns_q   <= ld_ns;
            frac_q <= '0;
        end else if (dl) begin
            if (dsum < 0) begin
                sec_q <= sec_q - SEC_W'(1);
                ns_q  <= NS_W'(dsum + BILLION_S);
            end else if (dsum >= BILLION_S) begin
                sec_q <= sec_q + SEC_W'(1);
                ns_q  <= NS_W'(dsum - BILLION_S);
            end else begin
                ns_q  <= NS_W'(dsum);
            end
        end else if (ena) begin
            frac_q <= frac_sum[FRAC_W-1:0];
            if (in_band) begin
                ns_q <= ns_add[NS_W-1:0];
            end else if (ns_add >= BILLION_U) begin
                ns_q  <= NS_W'(ns_add - BILLION_U);
                sec_q <= sec_q + SEC_W'(1);
            end else begin
                ns_q <= ns_add[NS_W-1:0];
            end
        end
    end

    assign sec = sec_q;
    assign ns  = ns_q;

endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
    import tod_pkg::*;
#(
    parameter int               NUM_DOM     = 3,
    parameter int               SEC_W       = 48,
    parameter int               NS_W        = 30,
    parameter int               INC_W       = 64,
    parameter int               FRAC_W      = 59,
    parameter logic [INC_W-1:0] NOMINAL_INC = INC_250MHZ,
    localparam int              DOM_W       = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic [0:0]         clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] dom_ena,
    input  logic [NUM_DOM-1:0] rate_hold,
    input  logic [31:0]        wdata,
    input  logic               rate_wr_lo,
    input  logic               rate_wr_hi,
    input  logic [DOM_W-1:0]   rate_dom,
    input  logic               sh_wr_sec_hi,
    input  logic               sh_wr_sec_lo,
    input  logic               sh_wr_ns,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_action,
    input  logic [DOM_W-1:0]   cmd_dom,
    output logic [SEC_W-1:0]   rd_sec,
    output logic [NS_W-1:0]    rd_ns
);

    port_st_e                        port_state;
    logic                            do_load;
    logic                            do_save;
    logic                            do_delta;

    logic [NUM_DOM-1:0]              ld_vec;
    logic [NUM_DOM-1:0]              dl_vec;
    logic [NUM_DOM-1:0][SEC_W-1:0]   dom_sec;
    logic [NUM_DOM-1:0][NS_W-1:0]    dom_ns;
    logic [NUM_DOM-1:0][INC_W-1:0]   dom_inc;

    logic [SEC_W-1:0]                sh_sec_q;
    logic [NS_W-1:0]                 sh_ns_q;
    logic [SEC_W-1:0]                sel_sec;
    logic [NS_W-1:0]                 sel_ns;
    logic                            sel_hit;

    tod_port_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_action (cmd_action),
        .state      (port_state),
        .do_load    (do_load),
        .do_save    (do_save),
        .do_delta   (do_delta)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic rate_sel;
        assign rate_sel  = (rate_dom == DOM_W'(d));
        assign ld_vec[d] = do_load  && (cmd_dom == DOM_W'(d));
        assign dl_vec[d] = do_delta && (cmd_dom == DOM_W'(d));

        tod_rate_reg #(
            .INC_W (INC_W),
            .INIT  (NOMINAL_INC)
        ) u_rate (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold   (rate_hold[d]),
            .wr_lo  (rate_wr_lo && rate_sel),
            .wr_hi  (rate_wr_hi && rate_sel),
            .wdata  (wdata),
            .active (dom_inc[d])
        );

        tod_domain #(
            .SEC_W  (SEC_W),
            .NS_W   (NS_W),
            .INC_W  (INC_W),
            .FRAC_W (FRAC_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ena    (dom_ena[d]),
            .inc    (dom_inc[d]),
            .ld     (ld_vec[d]),
            .ld_sec (sh_sec_q),
            .ld_ns  (sh_ns_q),
            .dl     (dl_vec[d]),
            .dl_ns  (sh_ns_q),
            .sec    (dom_sec[d]),
            .ns     (dom_ns[d])
        );
    end

    always_comb begin : select_domain
        sel_sec = '0;
        sel_ns  = '0;
        sel_hit = 1'b0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (cmd_dom == DOM_W'(d)) begin
                sel_sec = dom_sec[d];
                sel_ns  = dom_ns[d];
                sel_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin : shadow_regs
        if (!rst_n) begin
            sh_sec_q <= '0;
            sh_ns_q  <= '0;
        end else if (do_save && sel_hit) begin
            sh_sec_q <= sel_sec;
            sh_ns_q  <= sel_ns;
        end else begin
            if (sh_wr_sec_hi) begin
                sh_sec_q[SEC_W-1:32] <= wdata[SEC_W-33:0];
            end
            if (sh_wr_sec_lo) begin
                sh_sec_q[31:0] <= wdata;
            end
            if (sh_wr_ns) begin
                sh_ns_q <= wdata[NS_W-1:0];
            end
        end
    end

    assign rd_sec = sh_sec_q;
    assign rd_ns  = sh_ns_q;

endmodule

// File: rtl/tod_keeper_chk.sv
module tod_keeper_chk #(
    parameter int NUM_DOM = 3,
    parameter int SEC_W   = 48,
    parameter int NS_W    = 30,
    parameter int INC_W   = 64,
    parameter int DOM_W   = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_DOM-1:0]            dom_ena,
    input logic [NUM_DOM-1:0]            rate_hold,
    input logic [31:0]                   wdata,
    input logic                          sh_wr_ns,
    input logic                          cmd_valid,
    input logic [2:0]                    cmd_action,
    input logic [DOM_W-1:0]              cmd_dom,
    input logic [SEC_W-1:0]              rd_sec,
    input logic [NS_W-1:0]               rd_ns,
    input logic [2:0]                    port_state,
    input logic [NUM_DOM-1:0]            ld_vec,
    input logic [NUM_DOM-1:0]            dl_vec,
    input logic [NUM_DOM-1:0][SEC_W-1:0] dom_sec,
    input logic [NUM_DOM-1:0][NS_W-1:0]  dom_ns,
    input logic [NUM_DOM-1:0][INC_W-1:0] dom_inc
);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_chk
        // R3: a disabled domain that no command hits keeps its time
        a_r3_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!dom_ena[d] && !ld_vec[d] && !dl_vec[d])
            |=> ($stable(dom_sec[d]) && $stable(dom_ns[d])));

        // R2, R4: counting from a normal value only moves forward
        a_r2_moves_forward: assert property (@(posedge clk) disable iff (!rst_n)
            (dom_ena[d] && !ld_vec[d] && !dl_vec[d] && (dom_ns[d] < 30'd1_000_000_000))
            |=> ((dom_sec[d] == $past(dom_sec[d]) && dom_ns[d] >= $past(dom_ns[d])) ||
                 (dom_sec[d] == $past(dom_sec[d]) + SEC_W'(1) && dom_ns[d] < $past(dom_ns[d]))));

        // R5: the active increment stays put while the hold bit is set
        a_r5_hold_keeps_rate: assert property (@(posedge clk) disable iff (!rst_n)
            rate_hold[d] |=> $stable(dom_inc[d]));

        // R7: a save captures the selected domain's pre-edge time
        a_r7_save_captures: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_action == 3'd2 && cmd_dom == DOM_W'(d))
            |=> (rd_sec == $past(dom_sec[d]) && rd_ns == $past(dom_ns[d])));
    end

    // R10: codes 6 and 7 leave the port state alone
    a_r10_bad_code_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_action > 3'd5) |=> $stable(port_state));

    // R11: a shadow nanosecond write is visible next cycle when no save competes
    a_r11_ns_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_wr_ns && !(cmd_valid && cmd_action == 3'd2))
        |=> (rd_ns == $past(wdata[NS_W-1:0])));

endmodule

bind tod_keeper tod_keeper_chk #(
    .NUM_DOM (NUM_DOM),
    .SEC_W   (SEC_W),
    .NS_W    (NS_W),
    .INC_W   (INC_W),
    .DOM_W   (DOM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dom_ena    (dom_ena),
    .rate_hold  (rate_hold),
    .wdata      (wdata),
    .sh_wr_ns   (sh_wr_ns),
    .cmd_valid  (cmd_valid),
    .cmd_action (cmd_action),
    .cmd_dom    (cmd_dom),
    .rd_sec     (rd_sec),
    .rd_ns      (rd_ns),
    .port_state (port_state),
    .ld_vec     (ld_vec),
    .dl_vec     (dl_vec),
    .dom_sec    (dom_sec),
    .dom_ns     (dom_ns),
    .dom_inc    (dom_inc)
);

// File: tb/tod_keeper_test.sv
`timescale 1ns/1ps
module tod_keeper_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  dom_ena = '0;
    logic [2:0]  rate_hold = '0;
    logic [31:0] wdata = '0;
    logic        rate_wr_lo = 1'b0;
    logic        rate_wr_hi = 1'b0;
    logic [1:0]  rate_dom = '0;
    logic        sh_wr_sec_hi = 1'b0;
    logic        sh_wr_sec_lo = 1'b0;
    logic        sh_wr_ns = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_action = '0;
    logic [1:0]  cmd_dom = '0;
    logic [47:0] rd_sec;
    logic [29:0] rd_ns;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tod_keeper uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dom_ena      (dom_ena),
        .rate_hold    (rate_hold),
        .wdata        (wdata),
        .rate_wr_lo   (rate_wr_lo),
        .rate_wr_hi   (rate_wr_hi),
        .rate_dom     (rate_dom),
        .sh_wr_sec_hi (sh_wr_sec_hi),
        .sh_wr_sec_lo (sh_wr_sec_lo),
        .sh_wr_ns     (sh_wr_ns),
        .cmd_valid    (cmd_valid),
        .cmd_action   (cmd_action),
        .cmd_dom      (cmd_dom),
        .rd_sec       (rd_sec),
        .rd_ns        (rd_ns)
    );

    // {sec, ns, delta, expected sec, expected ns}
    localparam int NVEC = 7;
    localparam logic [185:0] VEC [NVEC] = '{
        {48'd7,             30'd500,        30'd100,        48'd7,             30'd600},
        {48'd1,             30'd999999900,  30'd200,        48'd2,             30'd100},
        {48'd3,             30'd50,         30'h3FFFFF9C,   48'd2,             30'd999999950},
        {48'd9,             30'h3FFFFFF8,   30'd20,         48'd9,             30'd12},
        {48'd20,            30'd400000000,  30'd673741824,  48'd20,            30'd0},
        {48'h0000FFFFFFFF,  30'd999999999,  30'd1,          48'h000100000000,  30'd0},
        {48'h000100000000,  30'd0,          30'h3FFFFFFF,   48'h0000FFFFFFFF,  30'd999999999}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] act, input logic [1:0] dom);
        cmd_valid  = 1'b1;
        cmd_action = act;
        cmd_dom    = dom;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wr_sh(input int which, input logic [31:0] d);
        wdata        = d;
        sh_wr_sec_hi = (which == 0);
        sh_wr_sec_lo = (which == 1);
        sh_wr_ns     = (which == 2);
        @(negedge clk);
        sh_wr_sec_hi = 1'b0;
        sh_wr_sec_lo = 1'b0;
        sh_wr_ns     = 1'b0;
    endtask

    task automatic wr_rate(input logic [1:0] dom, input logic hi, input logic [31:0] d);
        wdata      = d;
        rate_dom   = dom;
        rate_wr_lo = !hi;
        rate_wr_hi = hi;
        @(negedge clk);
        rate_wr_lo = 1'b0;
        rate_wr_hi = 1'b0;
    endtask

    task automatic load_dom(input logic [1:0] dom, input logic [47:0] s, input logic [29:0] n);
        do_cmd(3'd0, dom);
        wr_sh(0, {16'h0, s[47:32]});
        wr_sh(1, s[31:0]);
        wr_sh(2, {2'b00, n});
        do_cmd(3'd1, dom);
    endtask

    task automatic save_chk(input logic [1:0] dom, input string tag,
                            input logic [47:0] es, input logic [29:0] en);
        do_cmd(3'd2, dom);
        chk({tag, " sec"}, 64'(rd_sec), 64'(es));
        chk({tag, " ns"},  64'(rd_ns),  64'(en));
    endtask

    task automatic count_dom(input int d, input int n);
        dom_ena[d] = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of the shadows and a domain
        chk("R1 rd_sec after reset", 64'(rd_sec), 64'd0);
        chk("R1 rd_ns after reset",  64'(rd_ns),  64'd0);
        save_chk(2'd1, "R1 domain1 at reset", 48'd0, 30'd0);

        // set domain 1 to exactly 8 ns per cycle
        rate_hold[1] = 1'b1;
        wr_rate(2'd1, 1'b0, 32'h0);
        wr_rate(2'd1, 1'b1, 32'h4000_0000);
        rate_hold[1] = 1'b0;
        repeat (2) @(negedge clk);

        // R2 R4: 5 steps of 8 ns across a second boundary
        load_dom(2'd1, 48'd5, 30'd999999980);
        count_dom(1, 5);
        save_chk(2'd1, "R4 rollover", 48'd6, 30'd20);
        dom_ena[1] = 1'b0;

        // R5: new rate staged under hold, old rate stays
        rate_hold[1] = 1'b1;
        wr_rate(2'd1, 1'b0, 32'h0);
        wr_rate(2'd1, 1'b1, 32'h8000_0000);
        load_dom(2'd1, 48'd0, 30'd0);
        count_dom(1, 4);
        save_chk(2'd1, "R5 old rate under hold", 48'd0, 30'd32);
        dom_ena[1] = 1'b0;
        rate_hold[1] = 1'b0;
        repeat (2) @(negedge clk);
        load_dom(2'd1, 48'd0, 30'd0);
        count_dom(1, 4);
        save_chk(2'd1, "R5 new rate after release", 48'd0, 30'd64);
        dom_ena[1] = 1'b0;

        // R9: counting out of the negative band (-8 ns + 16 ns)
        load_dom(2'd1, 48'd10, 30'h3FFFFFF8);
        count_dom(1, 1);
        save_chk(2'd1, "R9 band count", 48'd10, 30'd8);
        dom_ena[1] = 1'b0;   // the save edge also counted: now 10 s 24 ns

        // R6: load from a non-idle state is ignored
        wr_sh(2, 32'd777);
        do_cmd(3'd1, 2'd1);
        save_chk(2'd1, "R6 load without idle", 48'd10, 30'd24);

        // R8 R10: action 3 leaves idle so a delta is ignored
        do_cmd(3'd0, 2'd1);
        wr_sh(2, 32'd100);
        do_cmd(3'd3, 2'd1);
        do_cmd(3'd4, 2'd1);
        save_chk(2'd1, "R8 delta blocked after code 3", 48'd10, 30'd24);

        // R10: code 7 keeps idle, so a following load works
        do_cmd(3'd0, 2'd1);
        wr_sh(0, 32'h0);
        wr_sh(1, 32'd77);
        wr_sh(2, 32'd5);
        do_cmd(3'd7, 2'd1);
        do_cmd(3'd1, 2'd1);
        save_chk(2'd1, "R10 code 7 keeps idle", 48'd77, 30'd5);

        // R1 R2: nominal rate from reset carries the fraction, 128 x 3.9921875 = 511
        load_dom(2'd2, 48'd0, 30'd0);
        count_dom(2, 128);
        save_chk(2'd2, "R2 fractional carry", 48'd0, 30'd511);
        dom_ena[2] = 1'b0;

        // R3: disabled domain 0 stays at zero while others run
        dom_ena = 3'b110;
        repeat (10) @(negedge clk);
        save_chk(2'd0, "R3 disabled domain", 48'd0, 30'd0);
        dom_ena = 3'b000;

        // R11: shadow field positions
        wr_sh(0, 32'hABCD_1234);
        wr_sh(1, 32'h89AB_CDEF);
        wr_sh(2, 32'h1234_5678);
        chk("R11 sec fields", 64'(rd_sec), 64'h1234_89AB_CDEF);
        chk("R11 ns field",   64'(rd_ns),  64'h1234_5678);
        wr_sh(2, 32'hFFFF_FFFF);
        chk("R11 ns truncation", 64'(rd_ns), 64'h3FFF_FFFF);

        // R8: signed delta vectors on stopped domain 0
        for (int i = 0; i < NVEC; i++) begin
            logic [185:0] v;
            v = VEC[i];
            load_dom(2'd0, v[185:138], v[137:108]);
            do_cmd(3'd0, 2'd0);
            wr_sh(2, {2'b00, v[107:78]});
            do_cmd(3'd4, 2'd0);
            save_chk(2'd0, $sformatf("R8 delta vector %0d", i), v[77:30], v[29:0]);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule